// File: doc/BRIEF.md
# Lockable Watchdog Timer

A watchdog counter governed entirely through one 32-bit control and status word. Software writes the word to set a timeout, start the count, pick the expiry mode, refill the count and freeze the setup. A built-in divider turns the input clock into a one-second tick. The count is zero-based, so a programmed value N allows N+1 ticks before the timer expires. If the timer runs out, the block raises a one-cycle request for a chip-wide reset. In the same cycle it drops its enable and sets one of two sticky flags. The mode bit in force at that moment picks which flag is set.

The flags live on a separate always-on reset. The ordinary reset, which is typically the one the request itself triggers, leaves them unchanged, so boot code can see why the system restarted. A lock bit freezes the setup until the ordinary reset. While locked, software can still refill the count, use an 8-bit scratch field and clear the flags. The register port is a plain write strobe with write data and a combinational read word. There is no streaming traffic, so there is no valid/ready handshake.

Top module: `guard_timer`

## Requirements
- R1: After both resets the register reads 0x0000_2000: only the mode bit (bit 13) is 1, and every other bit is 0.
- R2: Writing bit 14 (enable) from 0 to 1 with timeout N in bits 9:0 raises the request exactly DIV*(N+1) clock cycles after the write edge. DIV is CLK_HZ/TICK_HZ.
- R3: The reset request `sys_rst_req` stays high for exactly one cycle. In that same cycle, bit 14 reads 0, even when the lock is set.
- R4: At expiry, bit 25 is set if bit 13 is 1, and bit 24 is set if bit 13 is 0.
- R5: Bits 25 and 24 hold until a write with a 1 in that bit position. Writing 0 there has no effect. The clear also works while the lock is set.
- R6: Bits 25 and 24 survive `rst_n` and are cleared by `aon_rst_n`.
- R7: Writing 1 to bit 31 while enabled restarts a full DIV*(N+1) period from the write edge. Writing 0 to bit 31 leaves the running count untouched. Bit 31 always reads 0.
- R8: Writing bit 14 to 0 while running halts the count, and no request or flag follows.
- R9: With bit 12 (lock) set, writes to bits 15, 14, 13, 12 and 9:0 are ignored until `rst_n`.
- R10: Bits 23:16 are always read/write, including under lock, and writing them does not change the expiry time.
- R11: Bits 30:26 and 11:10 always read 0.
- R12: Writing 1 to bit 31 while disabled neither starts the timer nor changes any field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low ordinary reset (setup, count, divider) |
| aon_rst_n | input | 1 | Active-low always-on reset for the two expiry flags |
| wr_en | input | 1 | Register write strobe, one write per high cycle |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register contents (combinational) |
| sys_rst_req | output | 1 | One-cycle chip reset request on expiry |

## Verification
Three situations are hard to reach from the ports:
- **Expiry under lock.** The block must clear its own locked enable and still accept a flag clear. To get there, the bench writes enable and lock in a single write, then waits for the shortest timeout.
- **Flags across the ordinary reset.** Flags set by an expiry must survive `rst_n` and fall only on `aon_rst_n`. The bench pulses each reset alone.
- **Reload timing.** Each reload write lands a counted number of cycles into a running period. With the divider overridden to four cycles, every expiry can be predicted to the exact cycle.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
  localparam int REG_W      = 32;
  localparam int TOV_W      = 10;
  localparam int SCR_W      = 8;
  localparam int SCR_LSB    = 16;
  localparam int B_RELOAD   = 31;
  localparam int B_FLAG_SRV = 25;
  localparam int B_FLAG_PLN = 24;
  localparam int B_FORCE    = 15;
  localparam int B_EN       = 14;
  localparam int B_MODE     = 13;
  localparam int B_LOCK     = 12;
  localparam int NUM_FLAGS  = 2;

  typedef struct packed {
    logic             force_all;
    logic             en;
    logic             mode;
    logic             lock;
    logic [TOV_W-1:0] tov;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{force_all: 1'b0, en: 1'b0, mode: 1'b1,
                                 lock: 1'b0, tov: '0};
endpackage

// File: rtl/gt_tick_gen.sv
module gt_tick_gen #(
  parameter int DIV = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick = run && !restart;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] pcnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pcnt_q <= '0;
        else if (!run || restart)  pcnt_q <= '0;
        else if (pcnt_q == LAST)   pcnt_q <= '0;
        else                       pcnt_q <= pcnt_q + 1'b1;
      end

      assign tick = run && !restart && (pcnt_q == LAST);

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    end
  endgenerate
endmodule

// File: rtl/gt_countdown.sv
module gt_countdown #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt_q <= '0;
    else if (load)                          cnt_q <= load_val;
    else if (run && tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // A load in the same cycle pre-empts expiry: software refilled in time.
  assign expire = run && tick && !load && (cnt_q == '0);

  AST_CNT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/gt_regs.sv
module gt_regs
  import guard_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aon_rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             expire,
  output logic [REG_W-1:0] rd_data,
  output logic             run,
  output logic             load,
  output logic [TOV_W-1:0] load_val
);
  cfg_t                 cfg_q, cfg_d, cfg_wdata;
  logic [SCR_W-1:0]     scr_q;
  logic [NUM_FLAGS-1:0] flag_q, flag_d, flag_set, flag_clr;
  logic                 cfg_wr, start, reload, en_kept;

  assign cfg_wr = wr_en && !cfg_q.lock;

  always_comb begin
    cfg_wdata.force_all = wr_data[B_FORCE];
    cfg_wdata.en        = wr_data[B_EN];
    cfg_wdata.mode      = wr_data[B_MODE];
    cfg_wdata.lock      = wr_data[B_LOCK];
    cfg_wdata.tov       = wr_data[TOV_W-1:0];
  end

  always_comb begin
    cfg_d = cfg_wr ? cfg_wdata : cfg_q;
    if (expire) cfg_d.en = 1'b0;
  end

  assign en_kept  = cfg_wr ? wr_data[B_EN] : 1'b1;
  assign start    = cfg_wr && wr_data[B_EN] && !cfg_q.en;
  assign reload   = wr_en && wr_data[B_RELOAD] && cfg_q.en && en_kept;
  assign load     = start || reload;
  assign load_val = cfg_d.tov;
  assign run      = cfg_q.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      scr_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      if (wr_en) scr_q <= wr_data[SCR_LSB +: SCR_W];
    end
  end

  // Flag index 1 = survivability mode expiry, index 0 = plain mode expiry.
  always_comb begin
    flag_set[1] = expire && cfg_q.mode;
    flag_set[0] = expire && !cfg_q.mode;
    flag_clr[1] = wr_en && wr_data[B_FLAG_SRV];
    flag_clr[0] = wr_en && wr_data[B_FLAG_PLN];
    for (int i = 0; i < NUM_FLAGS; i++)
      flag_d[i] = (flag_q[i] && !flag_clr[i]) || flag_set[i];
  end

  always_ff @(posedge clk or negedge aon_rst_n) begin
    if (!aon_rst_n) flag_q <= '0;
    else            flag_q <= flag_d;
  end

  always_comb begin
    rd_data                        = '0;
    rd_data[B_FLAG_SRV]            = flag_q[1];
    rd_data[B_FLAG_PLN]            = flag_q[0];
    rd_data[SCR_LSB +: SCR_W]      = scr_q;
    rd_data[B_FORCE]               = cfg_q.force_all;
    rd_data[B_EN]                  = cfg_q.en;
    rd_data[B_MODE]                = cfg_q.mode;
    rd_data[B_LOCK]                = cfg_q.lock;
    rd_data[TOV_W-1:0]             = cfg_q.tov;
  end

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lock |=> ($stable(cfg_q.lock) && $stable(cfg_q.mode) &&
                    $stable(cfg_q.tov) && $stable(cfg_q.force_all))); // R9
  AST_LOCK_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.lock && !cfg_q.en) |=> !cfg_q.en); // R9
  AST_EXPIRE_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n || !aon_rst_n)
    expire |=> !cfg_q.en); // R3
  AST_MODE_SELECT: assert property (@(posedge clk) disable iff (!aon_rst_n || !rst_n)
    expire |=> (cfg_q.mode ? flag_q[1] : flag_q[0]) == 1'b1 || $past(cfg_q.mode) != cfg_q.mode ||
               ($past(cfg_q.mode) ? flag_q[1] : flag_q[0])); // R4
  AST_FLAG_SRV_STICKY: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (flag_q[1] && !(wr_en && wr_data[B_FLAG_SRV])) |=> flag_q[1]); // R5
  AST_FLAG_PLN_STICKY: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (flag_q[0] && !(wr_en && wr_data[B_FLAG_PLN])) |=> flag_q[0]); // R5
  AST_RELOAD_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[B_RELOAD] == 1'b0); // R7
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int CLK_HZ  = 100_000_000,
  parameter int TICK_HZ = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aon_rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             sys_rst_req
);
  localparam int DIV = (CLK_HZ / TICK_HZ) < 1 ? 1 : (CLK_HZ / TICK_HZ);

  logic             run, load, tick, expire, req_q;
  logic [TOV_W-1:0] load_val;

  gt_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .aon_rst_n (aon_rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .expire    (expire),
    .rd_data   (rd_data),
    .run       (run),
    .load      (load),
    .load_val  (load_val)
  );

  gt_tick_gen #(.DIV(DIV)) i_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (load),
    .tick    (tick)
  );

  gt_countdown #(.W(TOV_W)) i_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (tick),
    .load     (load),
    .load_val (load_val),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= expire;
  end

  assign sys_rst_req = req_q;

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req); // R3
  AST_REQ_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> !rd_data[B_EN]); // R3
endmodule

// File: tb/test_guard_timer.sv
module test_guard_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        aon_rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        sys_rst_req;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  localparam int DIV = 4;

  always #5 clk = ~clk;

  guard_timer #(.CLK_HZ(DIV), .TICK_HZ(1)) i_guard_timer (
    .clk(clk), .rst_n(rst_n), .aon_rst_n(aon_rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sys_rst_req(sys_rst_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(bit main_r, bit aon_r);
    @(negedge clk);
    if (main_r) rst_n = 1'b0;
    if (aon_r)  aon_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    aon_rst_n = 1'b1;
    #1;
  endtask

  task automatic wr(logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_req(output int k);
    k = 0;
    for (int i = 1; i <= 200; i++) begin
      @(posedge clk);
      #1;
      if (sys_rst_req) begin
        k = i;
        break;
      end
    end
  endtask

  task automatic count_req(int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      if (sys_rst_req) hits++;
    end
  endtask

  task automatic t_reset;
    do_reset(1, 1);
    chk("R1 reset value", rd_data, 32'h0000_2000);
    chk("R1 no request", {31'b0, sys_rst_req}, 32'h0);
  endtask

  task automatic t_expire_surv;
    int k;
    wr(32'h0000_6002);
    wait_req(k);
    chk("R2 expiry cycles N=2", k, DIV * 3);
    chk("R3 R4 enable dropped, bit25 set", rd_data, 32'h0200_2002);
    wait_cycles(1);
    chk("R3 single-cycle request", {31'b0, sys_rst_req}, 32'h0);
  endtask

  task automatic t_w1c;
    wr(32'h0000_2002);
    chk("R5 write 0 keeps flag", rd_data, 32'h0200_2002);
    wr(32'h0200_2002);
    chk("R5 write 1 clears flag", rd_data, 32'h0000_2002);
  endtask

  task automatic t_survive;
    int k;
    wr(32'h0000_6000);
    wait_req(k);
    chk("R2 expiry cycles N=0", k, DIV);
    do_reset(1, 0);
    chk("R6 flag survives rst_n", rd_data, 32'h0200_2000);
    do_reset(0, 1);
    chk("R6 aon reset clears flag", rd_data, 32'h0000_2000);
  endtask

  task automatic t_mode_plain;
    int k;
    wr(32'h0000_4001);
    wait_cycles(2);
    wr(32'h0055_4001);
    wait_req(k);
    chk("R10 scratch write leaves expiry time", k, DIV * 2 - 3);
    chk("R4 mode 0 sets bit24", rd_data, 32'h0155_0001);
    wr(32'h0100_0001);
    chk("R5 clear bit24", rd_data, 32'h0000_0001);
  endtask

  task automatic t_reload;
    int k;
    wr(32'h0000_6003);
    wait_cycles(6);
    wr(32'h0000_6003);
    wait_req(k);
    chk("R7 reload 0 no effect", k, DIV * 4 - 7);
    wr(32'h0200_2003);
    wr(32'h0000_6003);
    wait_cycles(6);
    wr(32'h8000_6003);
    chk("R7 reload bit reads 0", rd_data, 32'h0000_6003);
    wait_req(k);
    chk("R7 reload restarts period", k, DIV * 4);
    wr(32'h0200_2003);
    chk("R7 flag cleared after reload test", rd_data, 32'h0000_2003);
  endtask

  task automatic t_disable;
    int hits;
    wr(32'h0000_6001);
    wait_cycles(3);
    wr(32'h0000_2001);
    count_req(30, hits);
    chk("R8 no request after disable", hits, 0);
    chk("R8 no flag after disable", rd_data, 32'h0000_2001);
  endtask

  task automatic t_reload_idle;
    int hits;
    wr(32'h8000_0001);
    chk("R12 reload while idle", rd_data, 32'h0000_0001);
    count_req(30, hits);
    chk("R12 no start from reload", hits, 0);
  endtask

  task automatic t_lock;
    int hits;
    wr(32'h0000_1005);
    chk("R9 lock set", rd_data, 32'h0000_1005);
    wr(32'h0000_E3FF);
    chk("R9 locked fields ignored", rd_data, 32'h0000_1005);
    count_req(40, hits);
    chk("R9 locked enable ignored", hits, 0);
    wr(32'h00AB_E3FF);
    chk("R10 scratch writable under lock", rd_data, 32'h00AB_1005);
    do_reset(1, 1);
    chk("R9 rst_n releases lock", rd_data, 32'h0000_2000);
  endtask

  task automatic t_lock_expire;
    int k;
    wr(32'h0000_5000);
    wait_req(k);
    chk("R2 locked expiry cycles", k, DIV);
    chk("R3 enable cleared under lock", rd_data, 32'h0100_1000);
    wr(32'h0100_0000);
    chk("R5 clear under lock", rd_data, 32'h0000_1000);
    do_reset(1, 1);
  endtask

  task automatic t_reserved;
    wr(32'hFFFF_FFFF);
    chk("R11 reserved read 0", rd_data, 32'h00FF_F3FF);
    do_reset(1, 1);
    chk("R1 reset after all-ones", rd_data, 32'h0000_2000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_expire_surv();
    t_w1c();
    t_survive();
    t_mode_plain();
    t_reload();
    t_disable();
    t_reload_idle();
    t_lock();
    t_lock_expire();
    t_reserved();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule